// File: doc/BRIEF.md
# Subroutine Return Sequencer

This block carries out the two subroutine-return operations of a small 8-bit controller core. A 16-bit instruction word arrives over a valid/ready handshake. A phase-advance enable steps an internal four-phase counter (Q1 to Q4), and four phases make one instruction cycle. The block keeps a sixteen-entry return-address stack, the 8-bit working register and the interrupt mask bit. It raises a one-clock program-counter load strobe together with the popped address.

There are two recognised words. The first is a plain interrupt return, which pops the stack and clears the interrupt mask. The second is a return that also places an 8-bit literal in the working register. Each takes two instruction cycles. The first cycle does the work. The second cycle is a bubble, and during it the flush output tells the fetch stage to discard the word it has fetched. The high program-counter latch belongs to another block, and neither operation touches it. A push port models calls and interrupt entries.

Back-pressure: `instr_ready` is high only while the counter is at Q1, the phase enable is high and no second cycle is in progress. A word is taken on a clock edge where `instr_valid` and `instr_ready` are both high. While `instr_ready` is low, the source must hold its word steady.

Top module: `rtn_sequencer`

## Requirements
- R1: After reset, `irq_mask`=1, `wreg`=0, `pc_next`=0, `pc_load`=0, `flush`=0, `underflow`=0, `phase`=0 (Q1) and the stack is empty with every entry zero.
- R2: `phase` advances by one (0=Q1, 1=Q2, 2=Q3, 3=Q4, then back to 0) on each clock edge where `ph_adv` is high, and holds its value otherwise.
- R3: The word 0x0005 (interrupt return) is accepted at Q1. At the Q4 step of that cycle it pops the stack, `pc_next` takes the popped value and `pc_load` is high for exactly one clock.
- R4: A word whose bits [15:8] are 0xB6 (literal return) pops the stack into `pc_next` in the same way, and at that same Q4 step `wreg` takes bits [7:0] of the word. `wreg` changes at no other time.
- R5: `irq_mask` is cleared only at the Q3 step of the first cycle of an interrupt return. `gd_set` high at any clock edge sets `irq_mask`, and it wins over a clear at the same edge.
- R6: `flush` rises at the Q4 step of the first cycle and falls at the Q4 step of the second cycle. No word is accepted while `flush` is high.
- R7: `instr_ready` = (`phase`==Q1) and `ph_adv` and not `flush`.
- R8: The stack is last-in first-out and 16 deep. A pop from an empty stack wraps the pointer, reads entry 15 and sets the sticky `underflow` flag, which only reset clears.
- R9: Any other accepted word changes no state: it produces no pop, no `pc_load`, no `flush`, and `wreg` and `irq_mask` stay as they were.
- R10: `push_en` is honoured only on an edge where no return is held. A word is held from the edge after it is accepted to the end of its second cycle. Pushes on any other edge are ignored.
- R11: A lookup table built as a run of literal returns, entered with an offset of 7, leaves the eighth literal in `wreg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph_adv | input | 1 | Phase advance enable |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Instruction word can be taken |
| instr_word | input | 16 | Instruction word |
| push_en | input | 1 | Push a return address |
| push_addr | input | 16 | Address to push |
| gd_set | input | 1 | Request to set the interrupt mask |
| phase | output | 2 | Current phase, 0=Q1 to 3=Q4 |
| pc_load | output | 1 | One-clock program-counter load strobe |
| pc_next | output | 16 | Popped return address |
| wreg | output | 8 | Working register |
| irq_mask | output | 1 | Global interrupt disable bit |
| flush | output | 1 | Second-cycle stall and discard |
| underflow | output | 1 | Sticky stack underflow flag |

## Verification
On every cycle the assertions check the following:
- the phase stepping and holding;
- that the handshake opens only at Q1 outside a bubble;
- that the mask falls only after a Q3 step, and that a set request always lands;
- that the underflow flag stays set;
- that the working register moves only with a load strobe, and that each load strobe starts a bubble.

Only the bench's scenarios can show the rest:
- the last-in first-out order of the returned addresses;
- the literal that reaches the working register, including the table lookup;
- that pushes during a return are ignored;
- that foreign words leave all state alone.

// File: rtl/rtn_pkg.sv
package rtn_pkg;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_IRET = 2'd1, OP_LRET = 2'd2} rtn_op_e;
  localparam logic [15:0] IRET_WORD = 16'h0005;
  localparam logic [7:0]  LRET_HI   = 8'hB6;
  localparam logic [1:0]  PH_Q1 = 2'd0;
  localparam logic [1:0]  PH_Q2 = 2'd1;
  localparam logic [1:0]  PH_Q3 = 2'd2;
  localparam logic [1:0]  PH_Q4 = 2'd3;
endpackage

// File: rtl/rtn_decode.sv
module rtn_decode
  import rtn_pkg::*;
#(
  parameter int IW = 16,
  parameter int LW = 8
) (
  input  logic [IW-1:0] word,
  output rtn_op_e       op,
  output logic [LW-1:0] lit
);
  always_comb begin
    lit = word[LW-1:0];
    if (word == IRET_WORD)
      op = OP_IRET;
    else if (word[IW-1:IW-8] == LRET_HI)
      op = OP_LRET;
    else
      op = OP_NONE;
  end
endmodule

// File: rtl/rtn_phase.sv
module rtn_phase (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output logic [1:0] ph
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      ph <= 2'd0;
    else if (adv)
      ph <= ph + 2'd1;
  end
endmodule

// File: rtl/rtn_stack.sv
module rtn_stack #(
  parameter int DEPTH = 16,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_d,
  input  logic          pop,
  output logic [AW-1:0] tos,
  output logic          underflow
);
  localparam int SPW = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);

  logic [AW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp;
  logic [CW-1:0]  cnt;

  assign tos = mem[sp - SPW'(1)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp        <= '0;
      cnt       <= '0;
      underflow <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[sp] <= push_d;
      sp      <= sp + SPW'(1);
      if (cnt != CW'(DEPTH)) cnt <= cnt + CW'(1);
    end else if (pop) begin
      sp <= sp - SPW'(1);
      if (cnt == '0) underflow <= 1'b1;
      else           cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/rtn_sequencer.sv
module rtn_sequencer
  import rtn_pkg::*;
#(
  parameter int IW    = 16,
  parameter int LW    = 8,
  parameter int AW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph_adv,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [IW-1:0] instr_word,
  input  logic          push_en,
  input  logic [AW-1:0] push_addr,
  input  logic          gd_set,
  output logic [1:0]    phase,
  output logic          pc_load,
  output logic [AW-1:0] pc_next,
  output logic [LW-1:0] wreg,
  output logic          irq_mask,
  output logic          flush,
  output logic          underflow
);
  rtn_op_e       dec_op, op_q;
  logic [LW-1:0] dec_lit, lit_q;
  logic [AW-1:0] tos;
  logic          accept, held, do_pop, do_clr, do_push;

  rtn_phase u_phase (.clk(clk), .rst_n(rst_n), .adv(ph_adv), .ph(phase));

  rtn_decode #(.IW(IW), .LW(LW)) u_dec (.word(instr_word), .op(dec_op), .lit(dec_lit));

  rtn_stack #(.DEPTH(DEPTH), .AW(AW)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(do_push), .push_d(push_addr),
    .pop(do_pop), .tos(tos), .underflow(underflow)
  );

  assign instr_ready = (phase == PH_Q1) && ph_adv && !flush;
  assign accept      = instr_valid && instr_ready;
  assign held        = (op_q != OP_NONE) || flush;
  assign do_push     = push_en && !held;
  assign do_pop      = ph_adv && (phase == PH_Q4) && (op_q != OP_NONE) && !flush;
  assign do_clr      = ph_adv && (phase == PH_Q3) && (op_q == OP_IRET) && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q     <= OP_NONE;
      lit_q    <= '0;
      flush    <= 1'b0;
      pc_load  <= 1'b0;
      pc_next  <= '0;
      wreg     <= '0;
      irq_mask <= 1'b1;
    end else begin
      pc_load <= 1'b0;
      if (accept) begin
        op_q  <= dec_op;
        lit_q <= dec_lit;
      end
      if (gd_set)      irq_mask <= 1'b1;
      else if (do_clr) irq_mask <= 1'b0;
      if (do_pop) begin
        pc_next <= tos;
        pc_load <= 1'b1;
        flush   <= 1'b1;
        if (op_q == OP_LRET) wreg <= lit_q;
      end else if (flush && ph_adv && (phase == PH_Q4)) begin
        flush <= 1'b0;
        op_q  <= OP_NONE;
      end
    end
  end
endmodule

// File: rtl/rtn_sequencer_chk.sv
module rtn_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ph_adv,
  input logic       gd_set,
  input logic [1:0] phase,
  input logic       instr_ready,
  input logic       pc_load,
  input logic       flush,
  input logic       irq_mask,
  input logic       underflow,
  input logic [7:0] wreg
);
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_adv |=> phase == $past(phase) + 2'd1);
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_adv |=> $stable(phase));
  p_load_opens_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (flush && phase == 2'd0));
  p_ready_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ready |-> (phase == 2'd0 && !flush));
  p_mask_clear_q3_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_mask) |-> ($past(phase) == 2'd2 && $past(ph_adv)));
  p_mask_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gd_set |=> irq_mask);
  p_underflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  p_wreg_with_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wreg) |-> pc_load);
endmodule

bind rtn_sequencer rtn_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ph_adv(ph_adv), .gd_set(gd_set), .phase(phase),
  .instr_ready(instr_ready), .pc_load(pc_load), .flush(flush),
  .irq_mask(irq_mask), .underflow(underflow), .wreg(wreg)
);

// File: tb/sim_rtn_sequencer.sv
`timescale 1ns/100ps
module sim_rtn_sequencer;
  logic        clk = 0, rst_n = 0, ph_adv = 1, instr_valid = 0, push_en = 0, gd_set = 0;
  logic [15:0] instr_word = 0, push_addr = 0;
  logic        instr_ready, pc_load, irq_mask, flush, underflow;
  logic [1:0]  phase;
  logic [15:0] pc_next;
  logic [7:0]  wreg;
  int total = 0, bad = 0, cyc = 0;
  bit gate_mode = 0, done = 0;

  always #2.5 clk = ~clk;

  rtn_sequencer u0 (.*);

  // behavioural reference
  int m_ph, m_op, m_lit, m_c2, m_mask, m_wreg, m_pc, m_load, m_uf, m_sp, m_depth;
  int m_stk[16];

  always @(posedge clk) begin
    int dop; bit acc, clr;
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_op = 0; m_lit = 0; m_c2 = 0; m_mask = 1; m_wreg = 0; m_pc = 0;
      m_load = 0; m_uf = 0; m_sp = 0; m_depth = 0;
      foreach (m_stk[i]) m_stk[i] = 0;
    end else begin
      acc = instr_valid && (m_ph == 0) && ph_adv && !m_c2;
      dop = (instr_word == 16'h0005) ? 1 : (instr_word[15:8] == 8'hB6) ? 2 : 0;
      if (push_en && m_op == 0 && !m_c2) begin
        m_stk[m_sp] = push_addr; m_sp = (m_sp + 1) % 16;
        if (m_depth < 16) m_depth++;
      end
      m_load = 0;
      clr = ph_adv && m_ph == 2 && m_op == 1 && !m_c2;
      if (gd_set) m_mask = 1; else if (clr) m_mask = 0;
      if (ph_adv && m_ph == 3 && m_op != 0) begin
        if (!m_c2) begin
          m_sp = (m_sp + 15) % 16; m_pc = m_stk[m_sp];
          if (m_depth == 0) m_uf = 1; else m_depth--;
          m_load = 1; m_c2 = 1;
          if (m_op == 2) m_wreg = m_lit;
        end else begin
          m_c2 = 0; m_op = 0;
        end
      end
      if (acc) begin m_op = dop; m_lit = instr_word[7:0]; end
      if (ph_adv) m_ph = (m_ph + 1) % 4;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(phase == m_ph, "R2 phase", phase, m_ph);
    chk(pc_load == m_load && pc_next == m_pc, "R3 pc", pc_next, m_pc);
    chk(wreg == m_wreg, "R4 wreg", wreg, m_wreg);
    chk(irq_mask == m_mask, "R5 irq_mask", irq_mask, m_mask);
    chk(flush == m_c2, "R6 flush", flush, m_c2);
    chk(instr_ready == (m_ph == 0 && ph_adv && !m_c2), "R7 ready", instr_ready, 0);
    chk(underflow == m_uf, "R8 underflow", underflow, m_uf);
  end

  always @(posedge clk) begin
    #0.5;
    ph_adv = gate_mode ? ~ph_adv : 1'b1;
  end

  initial begin
    wait (cyc > 100000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic do_reset();
    @(posedge clk); #1; rst_n = 0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1;
  endtask

  task automatic push(logic [15:0] a);
    @(posedge clk); #1; push_en = 1; push_addr = a;
    @(posedge clk); #1; push_en = 0;
  endtask

  task automatic issue(logic [15:0] w);
    @(posedge clk); #1; instr_valid = 1; instr_word = w;
    while (1) begin
      #0.5;
      if (instr_ready) break;
      @(posedge clk); #1;
    end
    @(posedge clk); #1; instr_valid = 0; instr_word = 16'h0000;
  endtask

  task automatic wait_idle();
    do begin @(posedge clk); #1.5; end while (!(phase == 0 && !flush));
  endtask

  initial begin
    logic [7:0] tbl [10];
    do_reset();
    #1.5;
    chk(irq_mask == 1 && wreg == 0 && pc_next == 0 && !flush && !underflow && phase == 0,
        "R1 reset", {irq_mask, wreg}, 16'h100);

    // R4 then R3: LIFO returns
    push(16'h1234); push(16'h2222);
    issue(16'hB6A5); wait_idle();
    chk(wreg == 8'hA5, "R4 literal", wreg, 8'hA5);
    chk(pc_next == 16'h2222, "R4 popped pc", pc_next, 16'h2222);
    issue(16'h0005); wait_idle();
    chk(pc_next == 16'h1234, "R3 popped pc", pc_next, 16'h1234);
    chk(irq_mask == 0, "R5 cleared", irq_mask, 0);

    // R9 foreign word with gated phases (R2)
    gate_mode = 1;
    issue(16'h1234); wait_idle();
    chk(wreg == 8'hA5 && pc_next == 16'h1234 && irq_mask == 0, "R9 no change", wreg, 8'hA5);
    issue(16'hB7FF); wait_idle();
    chk(wreg == 8'hA5, "R9 near literal word", wreg, 8'hA5);

    // R5 set request over clear
    gate_mode = 0;
    push(16'h3333);
    @(posedge clk); #1; gd_set = 1;
    issue(16'h0005);
    repeat (4) @(posedge clk);
    #1; gd_set = 0; wait_idle();
    chk(irq_mask == 1, "R5 set wins", irq_mask, 1);
    chk(pc_next == 16'h3333, "R3 third pop", pc_next, 16'h3333);

    // R10 pushes during a return are ignored
    push(16'h0AAA); push(16'h0CCC);
    issue(16'hB611);
    #0.5; push_en = 1; push_addr = 16'h0BBB;
    repeat (3) @(posedge clk);
    #1; push_en = 0; wait_idle();
    chk(pc_next == 16'h0CCC && wreg == 8'h11, "R10 first", pc_next, 16'h0CCC);
    issue(16'h0005); wait_idle();
    chk(pc_next == 16'h0AAA, "R10 ignored push", pc_next, 16'h0AAA);

    // R11 table lookup with offset 7
    for (int i = 0; i < 10; i++) tbl[i] = 8'(8'h11 * i + 3);
    push(16'h0400);
    issue({8'hB6, tbl[7]}); wait_idle();
    chk(wreg == 8'h7A, "R11 eighth literal", wreg, 8'h7A);
    chk(pc_next == 16'h0400, "R11 return", pc_next, 16'h0400);

    // R8 underflow after fresh reset
    do_reset();
    issue(16'h0005); wait_idle();
    chk(underflow == 1 && pc_next == 0, "R8 underflow", underflow, 1);
    push(16'h5555);
    issue(16'hB600); wait_idle();
    chk(underflow == 1 && pc_next == 16'h5555, "R8 sticky", pc_next, 16'h5555);
    chk(flush == 0 && phase == 0, "R6 bubble over", flush, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule